// File: doc/BRIEF.md
# Multi-Page-Size Fully Associative Translation Buffer

This block caches virtual-to-physical address translations in a 64-slot array in which any translation may occupy any slot. Every slot records its own page size, one of four, and that size decides how many low address bits are left out of the tag compare and copied straight from the virtual address into the physical address. A lookup compares the incoming virtual address and context against all slots at once. In the same cycle it returns a hit flag, the physical address, a write-permission bit and a flag that reports more than one matching slot.

Translations enter through a fill port. Before a new translation is written, every valid slot whose page overlaps it in the same context is removed, so two slots can never match one lookup. A demap port removes the slots that cover a given address and context. An invalidate-all input empties the whole array. A slot that is being refilled is chosen with a used-bit approximation of least-recently-used order.

Top module: `mpsz_tlb`

## Requirements
- R1: A lookup is answered combinationally in the cycle it is presented. `lk_hit` is 1 only while `lk_valid` is 1 and a valid slot matches. `lk_pa` is the stored physical address above the page boundary, joined with the lookup address below it.
- R2: The page-size code is 2 bits. 0 means 8 KB and 13 offset bits, 1 means 64 KB and 16, 2 means 4 MB and 22, and 3 means 256 MB and 28. Offset bits are excluded from the compare. An address one byte past the page does not hit.
- R3: A slot hits only when its stored context equals the lookup context.
- R4: A fill first invalidates every valid slot that has the same context and whose virtual page overlaps the new one. Overlap is judged at the coarser of the two page sizes. The new translation is then written, and it hits on the next cycle.
- R5: `lk_multi` is 1 when more than one slot matches a valid lookup. Because of R4, it never fires after any sequence of fills.
- R6: A fill takes the lowest-index invalid slot if one exists. Slots freed by the overlap removal of the same fill count as invalid.
- R7: Each slot has a used bit that is set by a lookup hit or by a fill into it. When setting a bit would leave every bit set, all the other bits are cleared. When no slot is invalid, a fill replaces the lowest-index slot whose used bit is clear.
- R8: When a lookup and a fill occur in the same cycle, the lookup sees the state before the fill, and the lookup's used-bit update is dropped.
- R9: A demap invalidates every valid slot in the given context that covers the given address under the slot's own page size. A demap in the same cycle as a fill is ignored.
- R10: Invalidate-all clears every slot and every used bit. It overrides a fill or a demap in the same cycle.
- R11: After reset no lookup hits.
- R12: `lk_wr` returns the write-permission bit stored with the hitting slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request |
| lk_va | input | 48 | Lookup virtual address |
| lk_ctx | input | 13 | Lookup context |
| lk_hit | output | 1 | Lookup matched one or more slots |
| lk_pa | output | 40 | Translated physical address |
| lk_wr | output | 1 | Write permission of the matched slot |
| lk_multi | output | 1 | More than one slot matched |
| fill_valid | input | 1 | Write a new translation |
| fill_va | input | 48 | Virtual address of the new page |
| fill_ctx | input | 13 | Context of the new page |
| fill_pa | input | 40 | Physical address of the new page |
| fill_size | input | 2 | Page-size code of the new page |
| fill_wr | input | 1 | Write permission of the new page |
| demap_valid | input | 1 | Remove the pages that cover an address |
| demap_va | input | 48 | Address to demap |
| demap_ctx | input | 13 | Context to demap |
| inval_all | input | 1 | Clear every slot |

## Verification
Each page size is tried at its first byte, its last byte and one byte beyond it. This separates a correct offset width from one that is off by a bit or two. Overlapping fills of a large page and a small page, in the same context and in different contexts, show whether removal uses the coarser size and respects the context. A full array with one hand-picked used bit and one demapped hole checks that an invalid slot wins over a clear used bit, and that the lowest index wins among clear used bits. A long run of random fills, with many sizes crowded into a narrow address range, checks that each fill hits immediately and that no lookup ever matches twice.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    localparam int VA_W  = 48;
    localparam int PA_W  = 40;
    localparam int CTX_W = 13;

    typedef enum logic [1:0] {
        PG_8K   = 2'd0,
        PG_64K  = 2'd1,
        PG_4M   = 2'd2,
        PG_256M = 2'd3
    } pgsz_e;

    typedef struct packed {
        logic              valid;
        logic [CTX_W-1:0]  ctx;
        logic [VA_W-1:0]   vtag;
        logic [PA_W-1:0]   ptag;
        pgsz_e             size;
        logic              wr;
    } tlb_ent_t;

    function automatic int unsigned off_bits(pgsz_e s);
        case (s)
            PG_8K:   return 13;
            PG_64K:  return 16;
            PG_4M:   return 22;
            default: return 28;
        endcase
    endfunction

    // ones above the page boundary
    function automatic logic [VA_W-1:0] hi_mask(pgsz_e s);
        return ~((VA_W'(1) << off_bits(s)) - VA_W'(1));
    endfunction

    function automatic pgsz_e coarser(pgsz_e a, pgsz_e b);
        return (a > b) ? a : b;
    endfunction
endpackage

// File: rtl/tlb_match.sv
module tlb_match
    import tlb_pkg::*;
(
    input  tlb_ent_t          ent,
    input  logic [VA_W-1:0]   lk_va,
    input  logic [CTX_W-1:0]  lk_ctx,
    input  logic [VA_W-1:0]   fl_va,
    input  logic [CTX_W-1:0]  fl_ctx,
    input  pgsz_e             fl_size,
    input  logic [VA_W-1:0]   dm_va,
    input  logic [CTX_W-1:0]  dm_ctx,
    output logic              lk_match,
    output logic              fl_overlap,
    output logic              dm_match
);
    logic [VA_W-1:0] own_mask;
    logic [VA_W-1:0] wide_mask;

    always_comb begin
        own_mask   = hi_mask(ent.size);
        wide_mask  = hi_mask(coarser(ent.size, fl_size));
        lk_match   = ent.valid && (ent.ctx == lk_ctx) &&
                     (((ent.vtag ^ lk_va) & own_mask) == '0);
        fl_overlap = ent.valid && (ent.ctx == fl_ctx) &&
                     (((ent.vtag ^ fl_va) & wide_mask) == '0);
        dm_match   = ent.valid && (ent.ctx == dm_ctx) &&
                     (((ent.vtag ^ dm_va) & own_mask) == '0);
    end
endmodule

// File: rtl/tlb_plru.sv
module tlb_plru #(
    parameter int N  = 64,
    localparam int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr_all,
    input  logic          touch,
    input  logic [IW-1:0] touch_idx,
    input  logic [N-1:0]  valid_vec,
    output logic [IW-1:0] victim
);
    logic [N-1:0]  used_q;
    logic [N-1:0]  used_d;
    logic [N-1:0]  one_hot;
    logic [IW-1:0] inv_idx;
    logic [IW-1:0] clr_idx;
    logic          any_inv;

    always_comb begin
        one_hot = '0;
        one_hot[touch_idx] = 1'b1;
        used_d  = used_q | one_hot;
        if (&used_d) used_d = one_hot;
    end

    always_comb begin
        inv_idx = '0;
        clr_idx = '0;
        any_inv = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!valid_vec[i]) begin
                inv_idx = IW'(i);
                any_inv = 1'b1;
            end
            if (!used_q[i]) clr_idx = IW'(i);
        end
        victim = any_inv ? inv_idx : clr_idx;
    end

    always_ff @(posedge clk) begin
        if (rst || clr_all) used_q <= '0;
        else if (touch)     used_q <= used_d;
    end

    p_used_not_full_r7: assert property (@(posedge clk) disable iff (rst)
        !(&used_q));
endmodule

// File: rtl/mpsz_tlb.sv
module mpsz_tlb
    import tlb_pkg::*;
#(
    parameter int N_ENTRIES = 64,
    localparam int IW = $clog2(N_ENTRIES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lk_valid,
    input  logic [VA_W-1:0]   lk_va,
    input  logic [CTX_W-1:0]  lk_ctx,
    output logic              lk_hit,
    output logic [PA_W-1:0]   lk_pa,
    output logic              lk_wr,
    output logic              lk_multi,
    input  logic              fill_valid,
    input  logic [VA_W-1:0]   fill_va,
    input  logic [CTX_W-1:0]  fill_ctx,
    input  logic [PA_W-1:0]   fill_pa,
    input  logic [1:0]        fill_size,
    input  logic              fill_wr,
    input  logic              demap_valid,
    input  logic [VA_W-1:0]   demap_va,
    input  logic [CTX_W-1:0]  demap_ctx,
    input  logic              inval_all
);
    tlb_ent_t                ents [N_ENTRIES];
    logic [N_ENTRIES-1:0]    valid_vec;
    logic [N_ENTRIES-1:0]    hit_vec;
    logic [N_ENTRIES-1:0]    ovl_vec;
    logic [N_ENTRIES-1:0]    dm_vec;
    logic [IW-1:0]           victim;
    logic [IW-1:0]           hit_idx;
    logic                    plru_touch;
    logic [IW-1:0]           plru_idx;
    pgsz_e                   fsize;

    assign fsize = pgsz_e'(fill_size);

    for (genvar g = 0; g < N_ENTRIES; g++) begin : g_line
        assign valid_vec[g] = ents[g].valid;
        tlb_match u_match (
            .ent       (ents[g]),
            .lk_va     (lk_va),
            .lk_ctx    (lk_ctx),
            .fl_va     (fill_va),
            .fl_ctx    (fill_ctx),
            .fl_size   (fsize),
            .dm_va     (demap_va),
            .dm_ctx    (demap_ctx),
            .lk_match  (hit_vec[g]),
            .fl_overlap(ovl_vec[g]),
            .dm_match  (dm_vec[g])
        );
    end

    // lookup result: OR over matching slots
    always_comb begin
        logic [PA_W-1:0] pmask;
        lk_pa   = '0;
        lk_wr   = 1'b0;
        hit_idx = '0;
        for (int i = N_ENTRIES - 1; i >= 0; i--) begin
            pmask = hi_mask(ents[i].size)[PA_W-1:0];
            if (hit_vec[i]) begin
                lk_pa   = lk_pa | (ents[i].ptag & pmask) | (lk_va[PA_W-1:0] & ~pmask);
                lk_wr   = lk_wr | ents[i].wr;
                hit_idx = IW'(i);
            end
        end
        lk_hit   = lk_valid && (|hit_vec);
        lk_multi = lk_valid && ($countones(hit_vec) > 1);
    end

    assign plru_touch = !inval_all && (fill_valid || lk_hit);
    assign plru_idx   = fill_valid ? victim : hit_idx;

    tlb_plru #(.N(N_ENTRIES)) u_plru (
        .clk      (clk),
        .rst      (rst),
        .clr_all  (inval_all),
        .touch    (plru_touch),
        .touch_idx(plru_idx),
        .valid_vec(valid_vec & ~(fill_valid ? ovl_vec : '0)),
        .victim   (victim)
    );

    always_ff @(posedge clk) begin
        if (rst || inval_all) begin
            for (int i = 0; i < N_ENTRIES; i++) ents[i] <= '0;
        end else if (fill_valid) begin
            for (int i = 0; i < N_ENTRIES; i++)
                if (ovl_vec[i]) ents[i].valid <= 1'b0;
            ents[victim] <= '{valid: 1'b1, ctx: fill_ctx, vtag: fill_va,
                              ptag: fill_pa, size: fsize, wr: fill_wr};
        end else if (demap_valid) begin
            for (int i = 0; i < N_ENTRIES; i++)
                if (dm_vec[i]) ents[i].valid <= 1'b0;
        end
    end

    p_no_multi_r5: assert property (@(posedge clk) disable iff (rst)
        lk_valid |-> !lk_multi);

    p_fill_lands_r4: assert property (@(posedge clk) disable iff (rst)
        (fill_valid && !inval_all) |=> ents[$past(victim)].valid);

    p_inval_clears_r10: assert property (@(posedge clk) disable iff (rst)
        inval_all |=> (valid_vec == '0));

    p_hit_needs_req_r1: assert property (@(posedge clk) disable iff (rst)
        (lk_hit || lk_multi) |-> lk_valid);
endmodule

// File: tb/tb_mpsz_tlb.sv
module tb_mpsz_tlb;
    import tlb_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic              lk_valid = 0;
    logic [VA_W-1:0]   lk_va = '0;
    logic [CTX_W-1:0]  lk_ctx = '0;
    logic              lk_hit, lk_wr, lk_multi;
    logic [PA_W-1:0]   lk_pa;
    logic              fill_valid = 0;
    logic [VA_W-1:0]   fill_va = '0;
    logic [CTX_W-1:0]  fill_ctx = '0;
    logic [PA_W-1:0]   fill_pa = '0;
    logic [1:0]        fill_size = '0;
    logic              fill_wr = 0;
    logic              demap_valid = 0;
    logic [VA_W-1:0]   demap_va = '0;
    logic [CTX_W-1:0]  demap_ctx = '0;
    logic              inval_all = 0;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    mpsz_tlb dut (.*);

    function automatic int offw(int s);
        return (s == 0) ? 13 : (s == 1) ? 16 : (s == 2) ? 22 : 28;
    endfunction

    function automatic logic [PA_W-1:0] xlate(logic [PA_W-1:0] pa, logic [VA_W-1:0] va, int s);
        logic [PA_W-1:0] lo;
        lo = (PA_W'(1) << offw(s)) - 1;
        return (pa & ~lo) | (va[PA_W-1:0] & lo);
    endfunction

    task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // probe without touching used bits (released before the edge)
    task automatic probe(logic [VA_W-1:0] va, logic [CTX_W-1:0] c);
        lk_valid = 1; lk_va = va; lk_ctx = c;
        #1;
    endtask
    task automatic release_lk(); lk_valid = 0; endtask

    task automatic expect_hit(logic [VA_W-1:0] va, logic [CTX_W-1:0] c,
                              logic [PA_W-1:0] pa, string req);
        probe(va, c);
        chk(lk_hit === 1'b1, req, 64'(lk_hit), 64'd1);
        chk(lk_pa === pa, req, 64'(lk_pa), 64'(pa));
        release_lk();
    endtask
    task automatic expect_miss(logic [VA_W-1:0] va, logic [CTX_W-1:0] c, string req);
        probe(va, c);
        chk(lk_hit === 1'b0, req, 64'(lk_hit), 64'd0);
        release_lk();
    endtask

    task automatic do_fill(logic [VA_W-1:0] va, logic [CTX_W-1:0] c,
                           logic [PA_W-1:0] pa, int s, bit w);
        fill_valid = 1; fill_va = va; fill_ctx = c; fill_pa = pa;
        fill_size = 2'(s); fill_wr = w;
        @(negedge clk);
        fill_valid = 0;
    endtask
    task automatic do_demap(logic [VA_W-1:0] va, logic [CTX_W-1:0] c);
        demap_valid = 1; demap_va = va; demap_ctx = c;
        @(negedge clk);
        demap_valid = 0;
    endtask
    task automatic do_inval();
        inval_all = 1;
        @(negedge clk);
        inval_all = 0;
    endtask
    task automatic touch(logic [VA_W-1:0] va, logic [CTX_W-1:0] c);
        lk_valid = 1; lk_va = va; lk_ctx = c;
        @(negedge clk);
        lk_valid = 0;
    endtask

    localparam logic [VA_W-1:0] VB = 48'h1234_0000_0000;
    localparam logic [PA_W-1:0] PB = 40'h12_3000_0000;

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;

        // R11: empty after reset
        expect_miss(VB, 0, "R11");
        expect_miss('0, 0, "R11");

        // R2 / R1: each size, first byte, last byte, one past
        for (int s = 0; s < 4; s++) begin
            logic [VA_W-1:0] last;
            do_inval();
            do_fill(VB, 1, PB, s, 0);
            last = VB + (VA_W'(1) << offw(s)) - 1;
            expect_hit(VB, 1, PB, "R2");
            expect_hit(last, 1, xlate(PB, last, s), "R1");
            expect_miss(last + 1, 1, "R2");
        end

        // R3: context must match
        do_inval();
        do_fill(VB, 5, PB, 0, 0);
        expect_miss(VB, 6, "R3");
        expect_hit(VB, 5, PB, "R3");

        // R12: permission bit
        do_fill(VB + 48'h2000, 5, PB + 40'h2000, 0, 1);
        probe(VB + 48'h2000, 5); chk(lk_wr === 1'b1, "R12", 64'(lk_wr), 1); release_lk();
        probe(VB, 5);            chk(lk_wr === 1'b0, "R12", 64'(lk_wr), 0); release_lk();

        // R4: large page removed by overlapping small page, other context kept
        do_inval();
        do_fill(VB, 1, PB, 2, 0);
        do_fill(VB, 2, PB + 40'h40_0000, 2, 0);
        do_fill(VB + 48'h2000, 1, 40'h55_0000_0000, 0, 0);
        expect_miss(VB, 1, "R4");
        expect_hit(VB + 48'h2000, 1, 40'h55_0000_0000, "R4");
        expect_hit(VB + 48'h2000, 2, xlate(PB + 40'h40_0000, VB + 48'h2000, 2), "R4");
        // small page removed by a large page covering it
        do_fill(VB, 1, PB, 3, 0);
        expect_hit(VB + 48'h2000, 1, xlate(PB, VB + 48'h2000, 3), "R4");
        probe(VB + 48'h2000, 1); chk(lk_multi === 1'b0, "R5", 64'(lk_multi), 0); release_lk();

        // R8: lookup and fill in the same cycle
        do_inval();
        fill_valid = 1; fill_va = VB; fill_ctx = 3; fill_pa = PB; fill_size = 0; fill_wr = 0;
        lk_valid = 1; lk_va = VB; lk_ctx = 3;
        #1;
        chk(lk_hit === 1'b0, "R8", 64'(lk_hit), 0);
        @(negedge clk);
        fill_valid = 0; lk_valid = 0;
        expect_hit(VB, 3, PB, "R8");

        // R9: demap uses the slot's own size and context
        do_inval();
        do_fill(48'h2000_0000, 3, PB, 1, 0);
        do_demap(48'h2000_4000, 4);
        expect_hit(48'h2000_0000, 3, PB, "R9");
        do_demap(48'h2000_4000, 3);
        expect_miss(48'h2000_0000, 3, "R9");
        // demap ignored under a fill
        do_fill(48'h2000_0000, 3, PB, 1, 0);
        demap_valid = 1; demap_va = 48'h2000_0000; demap_ctx = 3;
        do_fill(48'h3000_0000, 3, PB + 40'h1_0000, 0, 0);
        demap_valid = 0;
        expect_hit(48'h2000_0000, 3, PB, "R9");
        expect_hit(48'h3000_0000, 3, PB + 40'h1_0000, "R9");

        // R10: invalidate-all beats fill
        inval_all = 1;
        do_fill(48'h4000_0000, 3, PB, 0, 0);
        inval_all = 0;
        expect_miss(48'h4000_0000, 3, "R10");
        expect_miss(48'h2000_0000, 3, "R10");

        // R6 / R7: replacement order
        do_inval();
        for (int i = 0; i < 64; i++)
            do_fill(48'h1000_0000 + 48'(i) * 48'h2000, 1, 40'h80_0000_0000 + 40'(i) * 40'h2000, 0, 0);
        for (int i = 0; i < 64; i += 9)
            expect_hit(48'h1000_0000 + 48'(i) * 48'h2000, 1, 40'h80_0000_0000 + 40'(i) * 40'h2000, "R6");
        touch(48'h1000_0000 + 48'd5 * 48'h2000, 1);
        do_fill(48'h7000_0000, 1, 40'h11_0000_0000, 0, 0);
        expect_miss(48'h1000_0000, 1, "R7");
        expect_hit(48'h1000_2000, 1, 40'h80_0000_2000, "R7");
        expect_hit(48'h7000_0000, 1, 40'h11_0000_0000, "R7");
        do_fill(48'h7100_0000, 1, 40'h12_0000_0000, 0, 0);
        expect_miss(48'h1000_2000, 1, "R7");
        expect_hit(48'h1000_4000, 1, 40'h80_0000_4000, "R7");
        expect_hit(48'h1000_0000 + 48'd5 * 48'h2000, 1, 40'h80_0000_0000 + 40'd5 * 40'h2000, "R7");
        do_demap(48'h1000_0000 + 48'd10 * 48'h2000, 1);
        do_fill(48'h7200_0000, 1, 40'h13_0000_0000, 0, 0);
        expect_hit(48'h1000_4000, 1, 40'h80_0000_4000, "R6");
        expect_hit(48'h7200_0000, 1, 40'h13_0000_0000, "R6");
        expect_hit(48'h1000_6000, 1, 40'h80_0000_6000, "R6");

        // R5: random crowded fills never produce a double match
        do_inval();
        for (int n = 0; n < 400; n++) begin
            logic [VA_W-1:0] va;
            logic [PA_W-1:0] pa;
            int s;
            logic [CTX_W-1:0] c;
            va = 48'($urandom & 32'h3FFF_E000);
            pa = 40'($urandom) << 8;
            s  = $urandom_range(0, 3);
            c  = 13'($urandom_range(0, 1));
            do_fill(va, c, pa, s, 0);
            probe(va, c);
            chk(lk_hit === 1'b1 && lk_pa === xlate(pa, va, s), "R5", 64'(lk_pa), 64'(xlate(pa, va, s)));
            chk(lk_multi === 1'b0, "R5", 64'(lk_multi), 0);
            release_lk();
            probe(48'($urandom & 32'h3FFF_FFFF), 13'($urandom_range(0, 1)));
            chk(lk_multi === 1'b0, "R5", 64'(lk_multi), 0);
            release_lk();
        end

        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule